// File: doc/BRIEF.md
# Masked Multi-Lane Vector Execution Unit

This unit runs one element-wise vector operation at a time. The operation is add, subtract, multiply, or a not-equal compare. The work is spread over a set of identical lanes. Element `i` goes to lane `i mod NLANES`, and all lanes share one control word. On each beat every lane handles one element. An operation over `vl` elements therefore takes `ceil(vl/NLANES)` beats. A one-cycle `done` pulse follows the last beat.

The unit holds three pieces of state:
- a destination vector register;
- a one-bit-per-element compare flag register;
- a one-bit-per-element exception flag register.

A compare writes its results into the compare flags. When `mask_en` is set, a later arithmetic operation uses those flags as a write mask. Signed overflow on add or subtract does not stop the operation. Instead, the overflow is recorded as a sticky bit in the exception flags for that element. Software checks these bits when it chooses.

The first operand comes either from a source vector or from a scalar that is broadcast to every element. Operands are captured when `start` is accepted, so they may change while the operation runs.

Top module: `vmask_exec`

## Requirements
- R1: With `use_scalar`=0, op code 0 (add) writes `a[i]+b[i]`, op code 1 (subtract) writes `a[i]-b[i]`, and op code 2 (multiply) writes the low `EW` bits of `a[i]*b[i]`. Each result goes to `vdst` element `i` for every `i < vl`. Sums and differences wrap modulo 2^EW. Element `i` occupies bits `[i*EW +: EW]` of every flat vector port.
- R2: With `use_scalar`=1, `scalar` replaces `a[i]` as the first operand for every element of add, subtract, multiply and compare.
- R3: Op code 3 (not-equal compare) sets `cmp_flags[i]` to 1 when the two operands of element `i` differ and to 0 when they are equal, for every `i < vl`. It leaves `vdst` and `exc_flags` unchanged.
- R4: With `mask_en`=1, an arithmetic operation writes only the elements whose `cmp_flags` bit is 1. Every other element of `vdst` keeps its previous value.
- R5: Elements at index `vl` or above keep their `vdst`, `cmp_flags` and `exc_flags` values.
- R6: A written add or subtract element whose signed result overflows sets its `exc_flags` bit. The bit stays set until reset. Multiply, compare, and masked-off or out-of-range elements never set it.
- R7: An operation accepted with `vl > 0` holds `busy` high for exactly `ceil(vl/NLANES)` cycles, then raises `done` for exactly one cycle. With `vl = 0`, `done` pulses in the cycle after acceptance, `busy` never rises, and no state changes.
- R8: A `start` sampled while `busy` is high is ignored. It changes no result and starts no new operation.
- R9: Synchronous reset clears `vdst`, `cmp_flags`, `exc_flags`, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation; accepted when not busy |
| op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 not-equal compare |
| use_scalar | input | 1 | Broadcast `scalar` as the first operand |
| mask_en | input | 1 | Mask arithmetic writes with `cmp_flags` |
| vl | input | $clog2(MAXVL+1) | Vector length, 0 to MAXVL |
| src_a | input | MAXVL*EW | First source vector |
| src_b | input | MAXVL*EW | Second source vector |
| scalar | input | EW | Scalar first operand |
| busy | output | 1 | Beats in progress |
| done | output | 1 | One-cycle completion pulse |
| vdst | output | MAXVL*EW | Destination vector register |
| cmp_flags | output | MAXVL | Compare / mask flag register |
| exc_flags | output | MAXVL | Sticky overflow flag register |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Vector lengths that are not a multiple of the lane count, and `vl = 0`.** A design that rounds the beat count wrongly, or writes the whole last beat, would corrupt the tail elements or report the wrong number of busy cycles.
- **Overflow on both add and subtract, in opposite sign directions.** A design with the wrong overflow test, or with flags that are not sticky, would show missing or spurious exception bits.
- **Masked subtract after a compare.** A design that ignores the mask, or inverts it, would overwrite elements it should have kept.
- **A second `start` during a busy operation.** A design that accepts it would return results for the intruding operation instead of the expected ones.

// File: rtl/vx_pkg.sv
package vx_pkg;

    typedef enum logic [1:0] {
        VX_ADD   = 2'd0,
        VX_SUB   = 2'd1,
        VX_MUL   = 2'd2,
        VX_CMPNE = 2'd3
    } vx_op_e;

    typedef struct packed {
        vx_op_e op;
        logic   use_scalar;
        logic   mask_en;
    } vx_ctrl_t;

    // signed overflow of a+b from sign bits of operands and result
    function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction

    // signed overflow of a-b
    function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
        return (sa != sb) && (sr != sa);
    endfunction

endpackage

// File: rtl/vx_lane.sv
module vx_lane
    import vx_pkg::*;
#(
    parameter int EW = 16
) (
    input  vx_op_e        op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] res,
    output logic          neq,
    output logic          ovf
);
    logic [2*EW-1:0] prod;

    always_comb begin
        prod = {{EW{1'b0}}, a} * {{EW{1'b0}}, b};
        neq  = (a != b);
        ovf  = 1'b0;
        unique case (op)
            VX_ADD: begin
                res = a + b;
                ovf = add_ovf(a[EW-1], b[EW-1], res[EW-1]);
            end
            VX_SUB: begin
                res = a - b;
                ovf = sub_ovf(a[EW-1], b[EW-1], res[EW-1]);
            end
            VX_MUL:  res = prod[EW-1:0];
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/vx_seq.sv
module vx_seq #(
    parameter int NLANES = 4,
    parameter int MAXVL  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [$clog2(MAXVL+1)-1:0]   vl,
    output logic                         accept,
    output logic                         busy,
    output logic                         done,
    output logic [$clog2(MAXVL/NLANES+1)-1:0] beat
);
    localparam int VLW   = $clog2(MAXVL+1);
    localparam int NBEAT = MAXVL / NLANES;
    localparam int BW    = $clog2(NBEAT+1);

    logic [VLW:0]  nb_full;
    logic [BW-1:0] nb, nb_q;

    assign accept  = start && !busy;
    assign nb_full = ({1'b0, vl} + (VLW+1)'(NLANES-1)) / (VLW+1)'(NLANES);
    assign nb      = BW'(nb_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            beat <= '0;
            nb_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                beat <= '0;
                nb_q <= nb;
                if (nb == '0) done <= 1'b1;
                else          busy <= 1'b1;
            end else if (busy) begin
                if (beat == nb_q - BW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    beat <= beat + BW'(1);
                end
            end
        end
    end

    assert_beat_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (beat < nb_q));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: rtl/vmask_exec.sv
module vmask_exec
    import vx_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int MAXVL  = 16,
    parameter int EW     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [1:0]                 op,
    input  logic                       use_scalar,
    input  logic                       mask_en,
    input  logic [$clog2(MAXVL+1)-1:0] vl,
    input  logic [MAXVL*EW-1:0]        src_a,
    input  logic [MAXVL*EW-1:0]        src_b,
    input  logic [EW-1:0]              scalar,
    output logic                       busy,
    output logic                       done,
    output logic [MAXVL*EW-1:0]        vdst,
    output logic [MAXVL-1:0]           cmp_flags,
    output logic [MAXVL-1:0]           exc_flags
);
    localparam int VLW   = $clog2(MAXVL+1);
    localparam int NBEAT = MAXVL / NLANES;
    localparam int BW    = $clog2(NBEAT+1);
    localparam int IW    = $clog2(MAXVL);

    logic          accept;
    logic [BW-1:0] beat;

    vx_ctrl_t           ctrl_q;
    logic [VLW-1:0]     vl_q;
    logic [EW-1:0]      scal_q;
    logic [EW-1:0]      opa_q [MAXVL];
    logic [EW-1:0]      opb_q [MAXVL];

    logic [EW-1:0]      lane_res [NLANES];
    logic [NLANES-1:0]  lane_neq;
    logic [NLANES-1:0]  lane_ovf;

    vx_seq #(.NLANES(NLANES), .MAXVL(MAXVL)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .vl     (vl),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .beat   (beat)
    );

    // operand capture on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{op: VX_ADD, use_scalar: 1'b0, mask_en: 1'b0};
            vl_q   <= '0;
            scal_q <= '0;
        end else if (accept) begin
            ctrl_q <= '{op: vx_op_e'(op), use_scalar: use_scalar, mask_en: mask_en};
            vl_q   <= vl;
            scal_q <= scalar;
        end
    end

    for (genvar i = 0; i < MAXVL; i++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (accept) begin
                opa_q[i] <= src_a[i*EW +: EW];
                opb_q[i] <= src_b[i*EW +: EW];
            end
        end
    end

    // lanes: lane l handles element beat*NLANES + l
    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [IW-1:0] eidx;
        logic [EW-1:0] a_in;
        assign eidx = IW'(beat) * IW'(NLANES) + IW'(l);
        assign a_in = ctrl_q.use_scalar ? scal_q : opa_q[eidx];

        vx_lane #(.EW(EW)) u_lane (
            .op  (ctrl_q.op),
            .a   (a_in),
            .b   (opb_q[eidx]),
            .res (lane_res[l]),
            .neq (lane_neq[l]),
            .ovf (lane_ovf[l])
        );
    end

    // per-element state, written by its own lane on its own beat
    for (genvar e = 0; e < MAXVL; e++) begin : g_elem
        localparam int LN = e % NLANES;
        localparam int BT = e / NLANES;
        logic [EW-1:0] vd_r;
        logic          cf_r, ef_r;
        logic          live, wr_en, cmp_en;

        assign live   = busy && (beat == BW'(BT)) && (VLW'(e) < vl_q);
        assign cmp_en = live && (ctrl_q.op == VX_CMPNE);
        assign wr_en  = live && (ctrl_q.op != VX_CMPNE) && (!ctrl_q.mask_en || cf_r);

        always_ff @(posedge clk) begin
            if (rst) begin
                vd_r <= '0;
                cf_r <= 1'b0;
                ef_r <= 1'b0;
            end else begin
                if (wr_en) begin
                    vd_r <= lane_res[LN];
                    if (lane_ovf[LN]) ef_r <= 1'b1;
                end
                if (cmp_en) cf_r <= lane_neq[LN];
            end
        end

        assign vdst[e*EW +: EW] = vd_r;
        assign cmp_flags[e]     = cf_r;
        assign exc_flags[e]     = ef_r;
    end

    assert_exc_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((exc_flags & $past(exc_flags)) == $past(exc_flags)));
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(vdst) && $stable(cmp_flags) && $stable(exc_flags)));
    assert_cmp_keeps_data_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_q.op == VX_CMPNE) |=> ($stable(vdst) && $stable(exc_flags)));
    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ctrl_q));

endmodule

// File: tb/vmask_exec_test.sv
module vmask_exec_test;
    import vx_pkg::*;

    localparam int NLANES = 4;
    localparam int MAXVL  = 16;
    localparam int EW     = 16;
    localparam int VLW    = $clog2(MAXVL+1);

    typedef struct {
        logic [MAXVL*EW-1:0] vd;
        logic [MAXVL-1:0]    cf;
        logic [MAXVL-1:0]    ef;
        int                  beats;
        string               tag;
    } item_t;

    logic clk = 0, rst = 1, start = 0, use_scalar = 0, mask_en = 0;
    logic [1:0] op = 0;
    logic [VLW-1:0] vl = 0;
    logic [MAXVL*EW-1:0] src_a = 0, src_b = 0;
    logic [EW-1:0] scalar = 0;
    logic busy, done;
    logic [MAXVL*EW-1:0] vdst;
    logic [MAXVL-1:0] cmp_flags, exc_flags;

    int checks = 0, errors = 0, busy_cnt = 0;
    bit finished = 0;
    item_t exp_q[$];

    logic [EW-1:0] ta [MAXVL];
    logic [EW-1:0] tb [MAXVL];
    logic [EW-1:0] m_vd [MAXVL];
    logic [MAXVL-1:0] m_cf = 0, m_ef = 0;

    always #5 clk = ~clk;

    vmask_exec #(.NLANES(NLANES), .MAXVL(MAXVL), .EW(EW)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .use_scalar(use_scalar),
        .mask_en(mask_en), .vl(vl), .src_a(src_a), .src_b(src_b), .scalar(scalar),
        .busy(busy), .done(done), .vdst(vdst), .cmp_flags(cmp_flags), .exc_flags(exc_flags)
    );

    task automatic check(input bit ok, input string what, input logic [MAXVL*EW-1:0] act,
                         input logic [MAXVL*EW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    // driver: compute expected from the model, push, then issue
    task automatic run_op(input vx_op_e o, input bit us, input bit me, input int n,
                          input logic [EW-1:0] s, input bit poke, input string tag);
        item_t it;
        logic [MAXVL*EW-1:0] fa, fb;
        for (int i = 0; i < n; i++) begin
            logic [EW-1:0] a, r;
            logic ov;
            a = us ? s : ta[i];
            if (o == VX_CMPNE) m_cf[i] = (a != tb[i]);
            else if (!me || m_cf[i]) begin
                ov = 1'b0;
                case (o)
                    VX_ADD: begin r = a + tb[i]; ov = (a[EW-1] == tb[i][EW-1]) && (r[EW-1] != a[EW-1]); end
                    VX_SUB: begin r = a - tb[i]; ov = (a[EW-1] != tb[i][EW-1]) && (r[EW-1] != a[EW-1]); end
                    default: r = EW'(32'(a) * 32'(tb[i]));
                endcase
                m_vd[i] = r;
                if (ov) m_ef[i] = 1'b1;
            end
        end
        for (int i = 0; i < MAXVL; i++) begin
            it.vd[i*EW +: EW] = m_vd[i];
            fa[i*EW +: EW] = ta[i];
            fb[i*EW +: EW] = tb[i];
        end
        it.cf = m_cf; it.ef = m_ef; it.beats = (n + NLANES - 1) / NLANES; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk); #1;
        op = o; use_scalar = us; mask_en = me; vl = VLW'(n); scalar = s;
        src_a = fa; src_b = fb; start = 1;
        @(posedge clk); #1;
        start = 0;
        src_a = ~fa; src_b = ~fb; scalar = ~s;
        if (poke) begin
            start = 1; op = 2'd2; vl = VLW'(MAXVL); mask_en = 0; use_scalar = 0;
            @(posedge clk); #1;
            start = 0;
        end
        while (!done) @(negedge clk);
        @(posedge clk); #1;
    endtask

    // monitor: count busy cycles, compare on done
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                item_t it;
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected done", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(vdst == it.vd, {it.tag, " vdst"}, vdst, it.vd);
                    check(cmp_flags == it.cf, {it.tag, " R3 cmp_flags"}, cmp_flags, it.cf);
                    check(exc_flags == it.ef, {it.tag, " R6 exc_flags"}, exc_flags, it.ef);
                    check(busy_cnt == it.beats, {it.tag, " R7 busy cycles"}, busy_cnt, it.beats);
                end
                busy_cnt = 0;
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAXVL; i++) m_vd[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(vdst == 0 && cmp_flags == 0 && exc_flags == 0 && !busy && !done,
              "R9 reset state", {vdst[15:0], cmp_flags, exc_flags}, 0);

        // R1 R6: vector add with a positive overflow at element 5
        for (int i = 0; i < MAXVL; i++) begin ta[i] = EW'(i * 16'h0111); tb[i] = EW'(16'h0300 + i); end
        ta[5] = 16'h7FFF; tb[5] = 16'h0001;
        run_op(VX_ADD, 0, 0, 16, 0, 0, "R1 R6 add vv");

        // R1 R5 R6: subtract, vl=7 (partial last beat), negative overflow at 2
        for (int i = 0; i < MAXVL; i++) begin ta[i] = EW'(16'h1000 - i * 3); tb[i] = EW'(i * 7); end
        ta[2] = 16'h8000; tb[2] = 16'h0001;
        run_op(VX_SUB, 0, 0, 7, 0, 0, "R1 R5 R6 sub vv vl7");

        // R1 R6: multiply never flags overflow
        for (int i = 0; i < MAXVL; i++) begin ta[i] = EW'(16'h0F00 + i * 31); tb[i] = EW'(i + 3); end
        run_op(VX_MUL, 0, 0, 16, 0, 0, "R1 R6 mul vv");

        // R2 R5: scalar add, vl=10
        for (int i = 0; i < MAXVL; i++) begin ta[i] = 16'hDEAD; tb[i] = EW'(i * 100); end
        run_op(VX_ADD, 1, 0, 10, 16'd3, 0, "R2 R5 add sv vl10");

        // R3 R5: compare not-equal, vl=13
        for (int i = 0; i < MAXVL; i++) begin ta[i] = EW'(i); tb[i] = (i % 3 == 0) ? EW'(i) : EW'(i + 1); end
        run_op(VX_CMPNE, 0, 0, 13, 0, 0, "R3 R5 cmpne vl13");

        // R4 R8: masked subtract with a start poke while busy
        for (int i = 0; i < MAXVL; i++) begin ta[i] = EW'(16'h2000 + i); tb[i] = EW'(i * 2); end
        run_op(VX_SUB, 0, 1, 16, 0, 1, "R4 R8 masked sub");

        // R7: vl = 0 does nothing
        run_op(VX_ADD, 0, 0, 0, 0, 0, "R7 vl0");

        // R2 R3: scalar compare, then masked scalar multiply
        for (int i = 0; i < MAXVL; i++) begin ta[i] = 16'h1111; tb[i] = (i % 2 == 0) ? 16'd9 : EW'(i); end
        run_op(VX_CMPNE, 1, 0, 16, 16'd9, 0, "R2 R3 cmpne sv");
        run_op(VX_MUL, 1, 1, 5, 16'd5, 0, "R2 R4 R5 masked mul sv vl5");

        // R6: saturated exception bits stay set after a clean add
        for (int i = 0; i < MAXVL; i++) begin ta[i] = 16'd1; tb[i] = 16'd1; end
        run_op(VX_ADD, 0, 0, 16, 0, 0, "R6 sticky exc");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 all operations completed", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule